// File: doc/BRIEF.md
# Debounced Input Change Detector

The block watches four asynchronous input pins and reports each level change that stays stable long enough to count. Each pin first passes through a two-flop synchronizer. A prescaler divides the system clock by 96 to make a slow sample tick. A per-pin filter accepts a new level only when two ticks in a row have seen it. With a 3.6864 MHz clock the tick runs at 38.4 kHz, so the filter rejects changes shorter than about 25 µs and always reports changes that stay stable longer than about 50 µs.

Every confirmed change sets a sticky flag for its pin, whether the level rose or fell. The CPU reads a status byte that holds these flags in the upper nibble and the current filtered levels in the lower nibble. The read clears all flags. A separately written mask selects which pending flags drive the interrupt request.

Top module: `pin_change_detect`

## Requirements
- R1: Each of the four pins passes through a two-flop synchronizer. stat_o[3:0] holds the filtered level of pins 3..0, with bit i for pin i. All filtered levels are 0 after reset.
- R2: The sample tick fires once every TICK_DIV (default 96) clock cycles and is never high on two cycles in a row.
- R3: A filtered level takes a new value only on a tick, and only after the synchronized pin has shown that value on two consecutive ticks. A pulse shorter than TICK_DIV cycles changes neither the level nor the flag.
- R4: Each confirmed change sets flag stat_o[4+i] for pin i. Rising and falling changes both set it.
- R5: A flag stays set until a read clears it.
- R6: When rd_stat_i is high in a cycle, stat_o in that cycle is the read data, and all flags are clear after that clock edge.
- R7: If a change is confirmed on the same edge as a read, the flag for that pin is set after the edge.
- R8: A cycle with mask_we_i high loads mask_wdata_i into the interrupt mask, with bit i for pin i. The mask is 0 after reset.
- R9: irq_o is the OR, over all pins, of (flag AND mask bit).
- R10: A read leaves the filtered levels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | 4 | Asynchronous monitored pins |
| rd_stat_i | input | 1 | Status read strobe; clears the flags |
| stat_o | output | 8 | {change flags[3:0], filtered levels[3:0]} |
| mask_we_i | input | 1 | Interrupt mask write strobe |
| mask_wdata_i | input | 4 | Interrupt mask write data |
| irq_o | output | 1 | Interrupt request |

## Verification
The clearing read and the confirmation of a change can fall on the same clock edge. The bench forces this by holding the read strobe high without a break while a pin changes level. It does not need to know the tick phase, because the collision is certain to happen on some edge. The bench counts the cycles in which the flag is visible while the read is held. It expects exactly one such cycle and expects the new level to appear. A design that lets the read win would show no cycle with the flag set.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int unsigned DEF_PINS = 4;
  localparam int unsigned DEF_DIV  = 96;

  typedef struct packed {
    logic level;
    logic chg;
  } filt_out_t;
endpackage

// File: rtl/pcd_sync.sv
module pcd_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pcd_tick.sv
module pcd_tick #(
  parameter int unsigned DIV = 96
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R2
endmodule

// File: rtl/pcd_filter.sv
module pcd_filter
  import pcd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      pin_i,
  output filt_out_t out_o
);
  logic level_q, cand_q;
  logic differs;

  assign differs   = (pin_i != level_q);
  assign out_o.chg = tick_i & differs & cand_q;
  assign out_o.level = level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      cand_q  <= 1'b0;
    end else if (tick_i) begin
      if (differs && cand_q) begin
        level_q <= pin_i;
        cand_q  <= 1'b0;
      end else begin
        cand_q  <= differs;
      end
    end
  end

  AST_LEVEL_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(level_q)); // R3
  AST_CONFIRM_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cand_q) |=> $stable(level_q)); // R3
endmodule

// File: rtl/pin_change_detect.sv
module pin_change_detect
  import pcd_pkg::*;
#(
  parameter int unsigned N_PINS   = DEF_PINS,
  parameter int unsigned TICK_DIV = DEF_DIV
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_PINS-1:0]     pins_i,
  input  logic                  rd_stat_i,
  output logic [2*N_PINS-1:0]   stat_o,
  input  logic                  mask_we_i,
  input  logic [N_PINS-1:0]     mask_wdata_i,
  output logic                  irq_o
);
  logic [N_PINS-1:0] pin_s, level, chg;
  logic [N_PINS-1:0] flag_q, mask_q;
  logic              tick;

  pcd_sync #(.WIDTH(N_PINS), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i(pins_i), .q_o(pin_s)
  );

  pcd_tick #(.DIV(TICK_DIV)) u_tick (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    filt_out_t fo;
    pcd_filter u_filt (
      .clk_i, .rst_ni, .tick_i(tick), .pin_i(pin_s[i]), .out_o(fo)
    );
    assign level[i] = fo.level;
    assign chg[i]   = fo.chg;
  end

  // new confirmations win over a clearing read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_q <= '0;
    else if (rd_stat_i) flag_q <= chg;
    else                flag_q <= flag_q | chg;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_wdata_i;
  end

  assign stat_o = {flag_q, level};
  assign irq_o  = |(flag_q & mask_q);

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_stat_i |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R5
  AST_READ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat_i && chg == '0) |=> (flag_q == '0)); // R6
  AST_NO_LOST_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat_i && chg != '0) |=> ((flag_q & $past(chg)) == $past(chg))); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o); // R9
  AST_READ_KEEPS_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat_i && chg == '0) |=> $stable(level)); // R10
endmodule

// File: tb/pin_change_detect_tb_top.sv
module pin_change_detect_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 250;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pins = '0;
  logic       rd = 1'b0;
  logic [7:0] stat;
  logic       mask_we = 1'b0;
  logic [3:0] mask_wd = '0;
  logic       irq;
  int         n_chk = 0;
  int         n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_change_detect dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .rd_stat_i(rd), .stat_o(stat),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wd), .irq_o(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(input string req, input logic [7:0] exp);
    @(negedge clk);
    rd = 1'b1;
    check(req, stat, exp);
    @(negedge clk);
    rd = 1'b0;
    check({req, " clear"}, {stat[7:4], 4'h0}, 8'h00);
  endtask

  task automatic t_reset();
    check("R1 reset stat", stat, 8'h00);
    check("R8 reset irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_tick_count();
    int ticks = 0;
    for (int c = 0; c < 960; c++) begin
      @(negedge clk);
      if (dut_i.u_tick.tick_o) ticks++;
    end
    check("R2 ticks in 960", 8'(ticks), 8'd10);
  endtask

  task automatic t_rise();
    @(negedge clk); pins = 4'b0001;
    wait_cyc(SETTLE);
    check("R4 rise flag/level", stat, 8'h11);
    wait_cyc(200);
    check("R5 sticky", stat, 8'h11);
    do_read("R6 read", 8'h11);
    check("R10 level kept", stat, 8'h01);
  endtask

  task automatic t_glitch();
    @(negedge clk); pins = 4'b0011;
    wait_cyc(40);
    pins = 4'b0001;
    wait_cyc(SETTLE);
    check("R3 glitch rejected", stat, 8'h01);
  endtask

  task automatic t_fall_multi();
    @(negedge clk); pins = 4'b1100;
    wait_cyc(SETTLE);
    check("R4 fall+rise flags", stat, 8'hDC);
    do_read("R6 read multi", 8'hDC);
  endtask

  task automatic t_irq();
    @(negedge clk); pins = 4'b1000;
    wait_cyc(SETTLE);
    check("R9 masked irq", {7'd0, irq}, 8'h00);
    mask_we = 1'b1; mask_wd = 4'b0100;
    @(negedge clk); mask_we = 1'b0;
    check("R9 irq on", {7'd0, irq}, 8'h01);
    mask_we = 1'b1; mask_wd = 4'b1000;
    @(negedge clk); mask_we = 1'b0;
    check("R8 other mask bit", {7'd0, irq}, 8'h00);
    do_read("R6 read irq", 8'h48);
  endtask

  task automatic t_collide();
    int seen = 0;
    @(negedge clk);
    rd = 1'b1;
    pins = 4'b1010;
    for (int c = 0; c < SETTLE; c++) begin
      @(negedge clk);
      if (stat[5]) seen++;
    end
    rd = 1'b0;
    check("R7 flag survived read", 8'(seen), 8'd1);
    check("R7 level", stat, 8'h0A);
  endtask

  initial begin
    bit done = 0;
    fork
      begin
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tick_count();
        t_rise();
        t_glitch();
        t_fall_multi();
        t_irq();
        t_collide();
        done = 1;
      end
      begin
        wait_cyc(20000);
      end
    join_any
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule